// File: doc/BRIEF.md
# Snoop Memory-Inhibit Controller

This block drives an active-high memory-inhibit line for a processor bus interface that watches the accesses of other bus masters. While the line is high, memory must not answer the current transfer, so that a cache lookup can decide first whether the cache holds the addressed data. The block follows bus ownership, transfer starts and transfer acknowledges. It also decodes a 2-bit snoop-control code that comes with each alternate-master access. From these it decides, one clock at a time, whether memory is blocked.

The line is high through reset and between bus cycles. It is released when the local processor starts a transfer, when an alternate-master access does not need snooping, or when an external cache stub reports a lookup miss. Acknowledges that arrive while the line is high are not counted. A line (burst) access is complete only after four counted acknowledges. The cache array, hit handling and bus arbitration lie outside the block.

Top module: `snoop_inhibit_ctl`

## Requirements
- R1: While reset is low, and after it until the first clock edge that samples a transfer start with the local grant high, the inhibit output is 1. Alternate-master starts seen before that edge do not clear it. The inhibit output is 0 after that edge.
- R2: From the between-cycles state, an alternate-master start (grant low) with snoop code 0 clears the inhibit output at the next edge, and no lookup is waited for.
- R3: An alternate-master start with snoop code 1, 2 or 3 keeps the inhibit output at 1 until an edge samples lookup-done high with lookup-hit low. The output is 0 after that edge.
- R4: A lookup that reports a hit keeps the inhibit output at 1. A pending lookup that sees the local grant rise moves to the between-cycles state, and the output stays 1.
- R5: When an alternate-master access completes, the inhibit output is 1 after the completing edge, unless that edge also samples a local start.
- R6: While the local processor owns the bus, the inhibit output stays 0, even after the grant drops during a transfer. It goes to 1 after the final acknowledge that completes the transfer with the grant low, or at once if the grant drops with no transfer in progress.
- R7: With the local grant high during an idle clock between cycles, the inhibit output is 1 during that clock. It goes to 0 after the edge that samples the local transfer start.
- R8: If the edge that completes an alternate-master access also samples a local start with the grant high, the inhibit output stays 0 throughout. No idle clock occurs, so inhibit is not asserted.
- R9: Normal and error acknowledges that arrive while the inhibit output is 1 are ignored. They count neither as beats nor as completion, so the later transfer still needs its full number of acknowledges.
- R10: A non-line access completes on its first counted acknowledge. A line access (line input high at the start) completes on its fourth counted acknowledge (BEATS = 4). A counted error acknowledge completes any access at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ownGrant | input | 1 | Local processor holds the bus |
| xferStart | input | 1 | Transfer start strobe |
| xferAck | input | 1 | Transfer acknowledge |
| xferErr | input | 1 | Transfer error acknowledge |
| snoopCode | input | 2 | Snoop-control code of the access; 0 means no snoop |
| lineXfer | input | 1 | Access is a four-beat line transfer |
| lookupDone | input | 1 | Cache stub has finished its lookup |
| lookupHit | input | 1 | Finished lookup found the line |
| memInhibit | output | 1 | Memory is blocked from responding |

## Verification
The inhibit output is a register. Any input sampled at a rising edge shows its effect on the output just after that same edge, one cycle after the stimulus was driven. The bench drives inputs at the falling edge and steps its own reference at the next rising edge. It compares the output at the following falling edge, so every comparison sees the result exactly one edge after its cause. Acknowledges sent during inhibited clocks are followed by the exact number of counted beats. This exposes a miscount at the single cycle where the output should return to 1.

// File: rtl/snoop_inhibit_pkg.sv
package snoop_inhibit_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_LOCAL  = 3'd1,
    ST_GAP    = 3'd2,
    ST_LOOKUP = 3'd3,
    ST_XFER   = 3'd4
  } inhState_t;

  typedef struct packed {
    logic load;
    logic line;
    logic count;
  } beatCtl_t;

endpackage

// File: rtl/snoop_beat_count.sv
module snoop_beat_count
  import snoop_inhibit_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  beatCtl_t ctl,
  output logic     lastBeat
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LINE_LOAD = CW'(BEATS - 1);

  logic [CW-1:0] beatsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatsLeft <= '0;
    end else if (ctl.load) begin
      beatsLeft <= ctl.line ? LINE_LOAD : '0;
    end else if (ctl.count && beatsLeft != '0) begin
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign lastBeat = (beatsLeft == '0);
endmodule

// File: rtl/snoop_inhibit_fsm.sv
module snoop_inhibit_fsm
  import snoop_inhibit_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ownGrant,
  input  logic              xferStart,
  input  logic              xferAck,
  input  logic              xferErr,
  input  logic [CODE_W-1:0] snoopCode,
  input  logic              lineXfer,
  input  logic              lookupDone,
  input  logic              lookupHit,
  input  logic              lastBeat,
  output beatCtl_t          beatCtl,
  output inhState_t         stateQ,
  output logic              inhibitQ
);
  inhState_t stateD;
  logic      busyQ, busyD;
  logic      ackAny, doneNow, localStart, altStart;

  assign ackAny     = xferAck | xferErr;
  assign doneNow    = ackAny & (xferErr | lastBeat);
  assign localStart = xferStart & ownGrant;
  assign altStart   = xferStart & ~ownGrant;

  always_comb begin
    stateD       = stateQ;
    busyD        = busyQ;
    beatCtl      = '0;
    beatCtl.line = lineXfer;
    unique case (stateQ)
      ST_HOLD: begin
        if (localStart) begin
          stateD       = ST_LOCAL;
          busyD        = 1'b1;
          beatCtl.load = 1'b1;
        end
      end
      ST_GAP: begin
        if (localStart) begin
          stateD       = ST_LOCAL;
          busyD        = 1'b1;
          beatCtl.load = 1'b1;
        end else if (altStart) begin
          stateD       = (snoopCode == '0) ? ST_XFER : ST_LOOKUP;
          beatCtl.load = 1'b1;
        end
      end
      ST_LOOKUP: begin
        if (ownGrant)                      stateD = ST_GAP;
        else if (lookupDone && !lookupHit) stateD = ST_XFER;
      end
      ST_XFER: begin
        if (doneNow) begin
          if (localStart) begin
            stateD       = ST_LOCAL;
            busyD        = 1'b1;
            beatCtl.load = 1'b1;
          end else begin
            stateD = ST_GAP;
          end
        end else if (ackAny) begin
          beatCtl.count = 1'b1;
        end
      end
      ST_LOCAL: begin
        if (busyQ) begin
          if (doneNow) begin
            if (!ownGrant) begin
              stateD = ST_GAP;
              busyD  = 1'b0;
            end else if (xferStart) begin
              beatCtl.load = 1'b1;
            end else begin
              busyD = 1'b0;
            end
          end else if (ackAny) begin
            beatCtl.count = 1'b1;
          end
        end else if (localStart) begin
          busyD        = 1'b1;
          beatCtl.load = 1'b1;
        end else if (!ownGrant) begin
          stateD = ST_GAP;
        end
      end
      default: stateD = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_HOLD;
      busyQ    <= 1'b0;
      inhibitQ <= 1'b1;
    end else begin
      stateQ   <= stateD;
      busyQ    <= busyD;
      inhibitQ <= (stateD == ST_HOLD) || (stateD == ST_GAP) ||
                  (stateD == ST_LOOKUP);
    end
  end
endmodule

// File: rtl/snoop_inhibit_ctl.sv
module snoop_inhibit_ctl
  import snoop_inhibit_pkg::*;
#(
  parameter int CODE_W = 2,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ownGrant,
  input  logic              xferStart,
  input  logic              xferAck,
  input  logic              xferErr,
  input  logic [CODE_W-1:0] snoopCode,
  input  logic              lineXfer,
  input  logic              lookupDone,
  input  logic              lookupHit,
  output logic              memInhibit
);
  beatCtl_t  beatCtl;
  logic      lastBeat;
  inhState_t ctrlState;

  snoop_inhibit_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rstN(rstN), .ownGrant(ownGrant), .xferStart(xferStart),
    .xferAck(xferAck), .xferErr(xferErr), .snoopCode(snoopCode),
    .lineXfer(lineXfer), .lookupDone(lookupDone), .lookupHit(lookupHit),
    .lastBeat(lastBeat), .beatCtl(beatCtl), .stateQ(ctrlState),
    .inhibitQ(memInhibit)
  );

  snoop_beat_count #(.BEATS(BEATS)) u_beats (
    .clk(clk), .rstN(rstN), .ctl(beatCtl), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/snoop_inhibit_chk.sv
module snoop_inhibit_chk
  import snoop_inhibit_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ownGrant,
  input logic              xferStart,
  input logic [CODE_W-1:0] snoopCode,
  input logic              lookupDone,
  input logic              lookupHit,
  input logic              memInhibit,
  input inhState_t         ctrlState
);
  logic seenLocal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      seenLocal <= 1'b0;
    else if (ownGrant && xferStart) seenLocal <= 1'b1;
  end

  p_reset_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !seenLocal |-> memInhibit);

  p_code0_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_GAP && xferStart && !ownGrant && snoopCode == '0)
      |=> !memInhibit);

  p_lookup_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_LOOKUP && !ownGrant && !(lookupDone && !lookupHit))
      |=> memInhibit);

  p_miss_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_LOOKUP && !ownGrant && lookupDone && !lookupHit)
      |=> !memInhibit);

  p_hit_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_LOOKUP && ownGrant) |=> memInhibit);

  p_local_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_LOCAL && ownGrant) |=> !memInhibit);

  p_gap_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlState == ST_GAP || ctrlState == ST_HOLD) && ownGrant && xferStart)
      |=> !memInhibit);

  p_gap_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_GAP && !xferStart) |=> memInhibit);
endmodule

bind snoop_inhibit_ctl snoop_inhibit_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ownGrant(ownGrant), .xferStart(xferStart),
  .snoopCode(snoopCode), .lookupDone(lookupDone), .lookupHit(lookupHit),
  .memInhibit(memInhibit), .ctrlState(ctrlState)
);

// File: tb/sim_snoop_inhibit_ctl.sv
`timescale 1ns/1ps
module sim_snoop_inhibit_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ownGrant = 0, xferStart = 0, xferAck = 0, xferErr = 0;
  logic [1:0] snoopCode = 0;
  logic lineXfer = 0, lookupDone = 0, lookupHit = 0;
  logic memInhibit;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  snoop_inhibit_ctl u0 (
    .clk(clk), .rstN(rstN), .ownGrant(ownGrant), .xferStart(xferStart),
    .xferAck(xferAck), .xferErr(xferErr), .snoopCode(snoopCode),
    .lineXfer(lineXfer), .lookupDone(lookupDone), .lookupHit(lookupHit),
    .memInhibit(memInhibit)
  );

  // reference model states: 0 hold, 1 local, 2 gap, 3 lookup, 4 alt transfer
  int mS = 0, mBeats = 0;
  bit mBusy = 0, mInh = 1;
  string mTag = "R1";

  function automatic int loadBeats(bit ln);
    return ln ? 3 : 0;
  endfunction

  task automatic modelStep();
    bit ack = xferAck | xferErr;
    bit done = ack && (xferErr || mBeats == 0);
    int nS = mS;
    if (!rstN) begin
      mS = 0; mBeats = 0; mBusy = 0; mInh = 1; mTag = "R1";
      return;
    end
    case (mS)
      0: begin
        mTag = "R1";
        if (xferStart && ownGrant) begin nS = 1; mBusy = 1; mBeats = loadBeats(lineXfer); end
      end
      2: begin
        mTag = "R9";
        if (xferStart && ownGrant) begin nS = 1; mBusy = 1; mBeats = loadBeats(lineXfer); mTag = "R7"; end
        else if (xferStart) begin
          nS = (snoopCode == 0) ? 4 : 3; mBeats = loadBeats(lineXfer);
          mTag = (snoopCode == 0) ? "R2" : "R3";
        end
      end
      3: begin
        mTag = (lookupDone && lookupHit) ? "R4" : "R3";
        if (ownGrant) begin nS = 2; mTag = "R4"; end
        else if (lookupDone && !lookupHit) nS = 4;
      end
      4: begin
        mTag = "R10";
        if (done) begin
          if (xferStart && ownGrant) begin nS = 1; mBusy = 1; mBeats = loadBeats(lineXfer); mTag = "R8"; end
          else begin nS = 2; mTag = "R5"; end
        end else if (ack && mBeats > 0) mBeats--;
      end
      default: begin
        mTag = "R6";
        if (mBusy) begin
          if (done) begin
            if (!ownGrant) begin nS = 2; mBusy = 0; end
            else if (xferStart) mBeats = loadBeats(lineXfer);
            else mBusy = 0;
          end else if (ack && mBeats > 0) mBeats--;
        end else if (xferStart && ownGrant) begin mBusy = 1; mBeats = loadBeats(lineXfer); end
        else if (!ownGrant) nS = 2;
      end
    endcase
    mS = nS;
    mInh = (mS == 0 || mS == 2 || mS == 3);
  endtask

  task automatic check(bit exp, string tag);
    nChecks++;
    if (memInhibit !== exp) begin
      nFails++;
      $display("FAIL %s: memInhibit actual %0b expected %0b at %0t", tag, memInhibit, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(mInh, mTag);
  endtask

  task automatic drive(bit gr, bit st, bit a, bit e, bit [1:0] code, bit ln, bit dn, bit hit);
    ownGrant = gr; xferStart = st; xferAck = a; xferErr = e;
    snoopCode = code; lineXfer = ln; lookupDone = dn; lookupHit = hit;
    step();
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: run actual hung expected finished");
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(1'b1, "R1");                  // in reset
    step(); step();
    rstN = 1'b1;
    drive(0,0,0,0,0,0,0,0); check(1'b1, "R1");
    drive(0,1,1,0,0,0,0,0); check(1'b1, "R1"); // alt start before first local cycle
    drive(1,1,0,0,0,0,0,0); check(1'b0, "R1"); // first local start
    drive(1,0,1,0,0,0,0,0); check(1'b0, "R6");
    drive(1,1,0,0,0,1,0,0);                     // local line start
    drive(0,0,1,0,0,0,0,0); check(1'b0, "R6");  // grant dropped mid transfer
    drive(0,0,1,0,0,0,0,0);
    drive(0,0,1,0,0,0,0,0); check(1'b0, "R6");
    drive(0,0,1,0,0,0,0,0); check(1'b1, "R6");  // final ack with grant low
    drive(0,0,1,1,0,0,0,0); check(1'b1, "R9");  // acks between cycles ignored
    drive(0,1,0,0,0,0,0,0); check(1'b0, "R2");  // code 0
    drive(0,0,1,0,0,0,0,0); check(1'b1, "R5");
    drive(0,1,0,0,2,1,0,0); check(1'b1, "R3");  // snooped line
    drive(0,0,1,0,0,0,0,0); check(1'b1, "R9");  // spurious ack
    drive(0,0,1,1,0,0,1,0); check(1'b0, "R3");  // miss, acks ignored
    drive(0,0,1,0,0,0,0,0); check(1'b0, "R10");
    drive(0,0,1,0,0,0,0,0);
    drive(0,0,1,0,0,0,0,0); check(1'b0, "R10");
    drive(0,0,1,0,0,0,0,0); check(1'b1, "R10"); // fourth counted ack
    drive(0,1,0,0,1,0,0,0); check(1'b1, "R3");
    drive(0,0,1,0,0,0,1,1); check(1'b1, "R4");  // hit holds
    drive(1,0,0,0,0,0,0,0); check(1'b1, "R4");  // grant rises, to gap
    drive(1,0,0,0,0,0,0,0); check(1'b1, "R7");  // idle clock
    drive(1,1,0,0,0,0,0,0); check(1'b0, "R7");
    drive(1,0,1,0,0,0,0,0);
    drive(0,0,0,0,0,0,0,0); check(1'b1, "R6");
    drive(0,1,0,0,3,0,0,0);
    drive(0,0,0,0,0,0,1,0); check(1'b0, "R3");
    drive(1,1,1,0,0,0,0,0); check(1'b0, "R8");  // no idle clock handover
    drive(1,0,0,0,0,0,0,0); check(1'b0, "R8");
    drive(1,0,1,0,0,0,0,0);
    drive(0,0,0,0,0,0,0,0);
    drive(0,1,0,0,0,1,0,0); check(1'b0, "R2");
    drive(0,0,0,1,0,0,0,0); check(1'b1, "R10"); // error ends line at once

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit gr = ownGrant;
      if (($urandom % 100) < 6) gr = ~gr;
      drive(gr, ($urandom % 100) < 20, ($urandom % 100) < 40, ($urandom % 100) < 4,
            2'($urandom), ($urandom % 2) == 1, ($urandom % 100) < 30, ($urandom % 100) < 30);
    end
    drive(0,0,0,0,0,0,0,0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule